// File: doc/BRIEF.md
# Packet Receive Buffer Controller

This block sits behind a line decoder that has already turned the serial medium into a stream of packet bytes. The stream is framed by a start strobe, a byte-valid strobe and an end strobe. The block writes each accepted packet into one page of a local 2048 x 8 RAM. A host selects that page with an arm command. The bytes land where a later transmit path would expect to find them: the sender and receiver identifiers first, then a length marker, and then the message body packed against the top of the page. A buffer that has been received can therefore be sent again after only its two identifier bytes are changed.

A completion flag reports that the last reception has finished and that reception is stopped. After reset the flag reads 1, so nothing is received until the host arms a page. An interrupt follows the flag through a host-writable mask. A configuration input chooses between eight 256-byte pages and four 512-byte pages. It also decides whether long packets, which are marked by a zero in the third byte, are accepted. Packets that are malformed, truncated or too long are dropped. When that happens the flag stays clear and the same page stays armed.

The host uses one register port with a read latency of one cycle. When address bit 11 is 1, the read returns the RAM byte at address bits 10:0. When it is 0, address bits 1:0 select a register. Index 0 is status, with the completion flag in bit 0. Index 1 is the arm command: a write takes its page number from data bits 2:0, and a read returns the current page. Index 2 is the interrupt mask, which uses bit 0.

Top module: `pkt_rx_buf`

## Requirements
- R1: After reset the completion flag is 1, the interrupt is 0, the page register reads 0 and the mask reads 0.
- R2: A write to register index 1 clears the completion flag in the next cycle and makes data bits 2:0 the destination page.
- R3: The irq output equals the completion flag ANDed with bit 0 of the mask register.
- R4: A short packet has a third byte M in the range 3 to 255, and its message length is 256-M. Its first byte is stored at page offset 0, its second at offset 1, M at offset 2, and its message bytes at offsets M through 255. The completion flag is set in the cycle after the final byte, which carries the end strobe and lands at offset 255.
- R5: When long_en is 1, pages are 512 bytes and the RAM address is {page[1:0], offset[8:0]}. A packet whose third byte is 0 is long. Its fourth byte L is stored at offset 3, and its message bytes are stored at offsets 256+L through 511.
- R6: When long_en is 0, pages are 256 bytes and the RAM address is {page[2:0], offset[7:0]}.
- R7: If the end strobe arrives before the last byte of the page, the completion flag stays 0. A correct packet that follows on the same armed page then completes normally.
- R8: When long_en is 0, a packet whose third byte is 0 is dropped and the completion flag stays 0.
- R9: While the completion flag is 1, stream bytes write nothing to the RAM and leave the flag at 1.
- R10: An arm command in the same cycle as a packet's final byte takes priority. That byte is not written, the flag stays 0 and the new page is armed.
- R11: A message byte that arrives after the last byte of the page, before the end strobe, drops the packet and the flag stays 0.
- R12: A short packet with a third byte of 1 or 2 is dropped and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_en | input | 1 | Configuration: 1 selects 512-byte pages and accepts long packets |
| rx_start | input | 1 | Marks the first byte of a packet; qualified by rx_valid |
| rx_valid | input | 1 | A stream byte is present on rx_data |
| rx_end | input | 1 | Marks the final byte of a packet; qualified by rx_valid |
| rx_data | input | 8 | Stream byte |
| host_addr | input | 12 | Bit 11 set reads RAM at bits 10:0; otherwise bits 1:0 select a register |
| host_we | input | 1 | Register write strobe |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Read data, one cycle after the address |
| irq | output | 1 | Completion interrupt, masked |

## Verification
Two events can fall in the same clock cycle: the host arm command and the final stream byte of a packet that would otherwise complete correctly. The bench provokes this by raising the register write in the exact cycle that carries the end strobe. It first fills the old page with a finished packet so that the byte at offset 255 has a known value. It then judges the outcome in four ways: the flag must still read 0, the page register must show the new page, offset 255 of the old page must keep its earlier value, and a later packet must land in the new page.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 11;
    localparam int OFF_W    = 9;
    localparam int PAGE_W   = ADDR_W - OFF_W + 1;
    localparam int MIN_MARK = 3;
    localparam int REG_STAT = 0;
    localparam int REG_CMD  = 1;
    localparam int REG_MASK = 2;

    typedef enum logic [2:0] {
        PH_IDLE, PH_DEST, PH_MARK, PH_LOFF, PH_DATA, PH_SKIP
    } phase_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // page number joined with an in-page offset; big selects 512-byte pages
    function automatic logic [ADDR_W-1:0] page_addr(
        input logic [PAGE_W-1:0] pg, input logic [OFF_W-1:0] off, input logic big);
        return big ? {pg[PAGE_W-2:0], off} : {pg, off[OFF_W-2:0]};
    endfunction
endpackage

// File: rtl/pkt_rx_ram.sv
module pkt_rx_ram #(
    parameter int AW = 11,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pkt_rx_placer.sv
module pkt_rx_placer import pkt_rx_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              armed_i,
    input  logic              abort_i,
    input  logic              long_en_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              rx_start_i,
    input  logic              rx_valid_i,
    input  logic              rx_end_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    output wr_req_t           wr_o,
    output logic              done_o
);
    localparam logic [OFF_W-1:0] SHORT_END = OFF_W'((1 << (OFF_W - 1)) - 1);
    localparam logic [OFF_W-1:0] LONG_END  = OFF_W'((1 << OFF_W) - 1);

    phase_t           phase_q, phase_d;
    logic [OFF_W-1:0] ptr_q, ptr_d, off, last_off;
    logic             long_q, long_d, write;

    always_comb begin
        phase_d  = phase_q;
        ptr_d    = ptr_q;
        long_d   = long_q;
        write    = 1'b0;
        off      = '0;
        done_o   = 1'b0;
        last_off = long_q ? LONG_END : SHORT_END;
        if (!armed_i || abort_i) begin
            phase_d = PH_IDLE;
        end else if (rx_valid_i) begin
            if (rx_start_i) begin
                write   = 1'b1;
                long_d  = 1'b0;
                phase_d = rx_end_i ? PH_IDLE : PH_DEST;
            end else begin
                case (phase_q)
                    PH_DEST: begin
                        write   = 1'b1;
                        off     = OFF_W'(1);
                        phase_d = rx_end_i ? PH_IDLE : PH_MARK;
                    end
                    PH_MARK: begin
                        if (rx_data_i == '0) begin
                            if (long_en_i) begin
                                write   = 1'b1;
                                off     = OFF_W'(2);
                                long_d  = 1'b1;
                                phase_d = rx_end_i ? PH_IDLE : PH_LOFF;
                            end else begin
                                phase_d = rx_end_i ? PH_IDLE : PH_SKIP;
                            end
                        end else if (rx_data_i < BYTE_W'(MIN_MARK)) begin
                            phase_d = rx_end_i ? PH_IDLE : PH_SKIP;
                        end else begin
                            write   = 1'b1;
                            off     = OFF_W'(2);
                            ptr_d   = {1'b0, rx_data_i};
                            phase_d = rx_end_i ? PH_IDLE : PH_DATA;
                        end
                    end
                    PH_LOFF: begin
                        write   = 1'b1;
                        off     = OFF_W'(3);
                        ptr_d   = {1'b1, rx_data_i};
                        phase_d = rx_end_i ? PH_IDLE : PH_DATA;
                    end
                    PH_DATA: begin
                        write = 1'b1;
                        off   = ptr_q;
                        if (rx_end_i) begin
                            phase_d = PH_IDLE;
                            done_o  = (ptr_q == last_off);
                        end else if (ptr_q == last_off) begin
                            phase_d = PH_SKIP;
                        end else begin
                            ptr_d = ptr_q + 1'b1;
                        end
                    end
                    default: begin
                        if (rx_end_i) phase_d = PH_IDLE;
                    end
                endcase
            end
        end
        wr_o.en   = write;
        wr_o.addr = page_addr(page_i, off, long_en_i);
        wr_o.data = rx_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ptr_q   <= '0;
            long_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            ptr_q   <= ptr_d;
            long_q  <= long_d;
        end
    end

    // R9
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !armed_i |-> !wr_o.en);
    // R10
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        abort_i |-> (!wr_o.en && !done_o));
    // R4
    done_on_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (rx_valid_i && rx_end_i && wr_o.en));
endmodule

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl import pkt_rx_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W:0]   host_addr_i,
    input  logic              host_we_i,
    input  logic [BYTE_W-1:0] host_wdata_i,
    input  logic              done_i,
    input  logic [BYTE_W-1:0] ram_rdata_i,
    output logic [ADDR_W-1:0] ram_raddr_o,
    output logic              armed_o,
    output logic              abort_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] host_rdata_o
);
    logic              is_ram, cmd_wr, mask_wr, ri_q, sel_ram_q;
    logic [BYTE_W-1:0] page_q, mask_q, reg_rd_q, reg_rd_d;

    assign is_ram  = host_addr_i[ADDR_W];
    assign cmd_wr  = host_we_i && !is_ram && (host_addr_i[1:0] == 2'(REG_CMD));
    assign mask_wr = host_we_i && !is_ram && (host_addr_i[1:0] == 2'(REG_MASK));

    always_comb begin
        case (host_addr_i[1:0])
            2'(REG_STAT): reg_rd_d = {{(BYTE_W-1){1'b0}}, ri_q};
            2'(REG_CMD):  reg_rd_d = page_q;
            2'(REG_MASK): reg_rd_d = mask_q;
            default:      reg_rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ri_q      <= 1'b1;
            page_q    <= '0;
            mask_q    <= '0;
            reg_rd_q  <= '0;
            sel_ram_q <= 1'b0;
        end else begin
            if (cmd_wr) begin
                ri_q   <= 1'b0;
                page_q <= host_wdata_i;
            end else if (done_i) begin
                ri_q <= 1'b1;
            end
            if (mask_wr) mask_q <= host_wdata_i;
            reg_rd_q  <= reg_rd_d;
            sel_ram_q <= is_ram;
        end
    end

    assign ram_raddr_o  = host_addr_i[ADDR_W-1:0];
    assign armed_o      = !ri_q;
    assign abort_o      = cmd_wr;
    assign page_o       = page_q[PAGE_W-1:0];
    assign irq_o        = ri_q & mask_q[0];
    assign host_rdata_o = sel_ram_q ? ram_rdata_i : reg_rd_q;

    // R2
    arm_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> !ri_q);
    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ri_q) |-> $past(done_i));
endmodule

// File: rtl/pkt_rx_buf.sv
module pkt_rx_buf import pkt_rx_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              long_en,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic              rx_end,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic [ADDR_W:0]   host_addr,
    input  logic              host_we,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              irq
);
    wr_req_t           wr;
    logic              done, armed, abort;
    logic [PAGE_W-1:0] page;
    logic [ADDR_W-1:0] raddr;
    logic [BYTE_W-1:0] rdata;

    pkt_rx_placer u_placer (
        .clk, .rst, .armed_i(armed), .abort_i(abort), .long_en_i(long_en),
        .page_i(page), .rx_start_i(rx_start), .rx_valid_i(rx_valid),
        .rx_end_i(rx_end), .rx_data_i(rx_data), .wr_o(wr), .done_o(done)
    );

    pkt_rx_ctrl u_ctrl (
        .clk, .rst, .host_addr_i(host_addr), .host_we_i(host_we),
        .host_wdata_i(host_wdata), .done_i(done), .ram_rdata_i(rdata),
        .ram_raddr_o(raddr), .armed_o(armed), .abort_o(abort), .page_o(page),
        .irq_o(irq), .host_rdata_o(host_rdata)
    );

    pkt_rx_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_ram (
        .clk, .we(wr.en), .waddr(wr.addr), .wdata(wr.data),
        .raddr(raddr), .rdata(rdata)
    );
endmodule

// File: tb/pkt_rx_buf_bench.sv
module pkt_rx_buf_bench;
    logic        clk = 1'b0, rst = 1'b1, long_en = 1'b0;
    logic        rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0;
    logic [7:0]  rx_data = '0, host_wdata = '0, host_rdata;
    logic [11:0] host_addr = '0;
    logic        host_we = 1'b0, irq;
    int          checks = 0, errors = 0;

    always #5 clk = ~clk;

    pkt_rx_buf u_pkt_rx_buf (.*);

    typedef struct packed {
        logic [2:0] pg;
        logic [7:0] mark;
        logic [7:0] sid;
        logic [7:0] did;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{3'd0, 8'd250, 8'h11, 8'h21},
        '{3'd7, 8'd200, 8'h12, 8'h22},
        '{3'd3, 8'd3,   8'h13, 8'h23},
        '{3'd5, 8'd128, 8'h14, 8'h24}
    };

    function automatic logic [7:0] pat(input int seed, input int j);
        return 8'((seed * 13 + j * 7 + 1) & 255);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk); host_we = 1'b0; host_addr = a;
        @(negedge clk); d = host_rdata;
    endtask

    task automatic rd_ram(input int a, output logic [7:0] d);
        rd({1'b1, 11'(a)}, d);
    endtask

    task automatic wr_reg(input int idx, input logic [7:0] v);
        @(negedge clk); host_we = 1'b1; host_addr = 12'(idx); host_wdata = v;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] sid, input logic [7:0] did,
                        input logic [7:0] mark, input logic [7:0] loff, input bit lng,
                        input int ndata, input int seed, input bit cmd_last,
                        input logic [7:0] cmd_pg);
        int hdr, total;
        hdr   = lng ? 4 : 3;
        total = hdr + ndata;
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_start = (k == 0);
            rx_end   = (k == total - 1);
            rx_data  = (k == 0) ? sid : (k == 1) ? did : (k == 2) ? mark :
                       (lng && k == 3) ? loff : pat(seed, k - hdr);
            if (cmd_last && k == total - 1) begin
                host_we = 1'b1; host_addr = 12'h001; host_wdata = cmd_pg;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_start = 1'b0; rx_end = 1'b0; host_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d, old255;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(12'h000, d); chk("R1 flag", d, 1);
        chk("R1 irq", irq, 0);
        rd(12'h001, d); chk("R1 page", d, 0);
        rd(12'h002, d); chk("R1 mask", d, 0);

        // R4 R6 short packets into several pages
        for (int v = 0; v < 4; v++) begin
            wr_reg(1, 8'(VECS[v].pg));
            rd(12'h000, d); chk("R2 armed", d, 0);
            send(VECS[v].sid, VECS[v].did, VECS[v].mark, 8'h0, 1'b0,
                 256 - VECS[v].mark, v + 1, 1'b0, 8'h0);
            rd(12'h000, d); chk("R4 flag", d, 1);
            base = VECS[v].pg * 256;
            rd_ram(base, d);     chk("R4 sid", d, VECS[v].sid);
            rd_ram(base + 1, d); chk("R4 did", d, VECS[v].did);
            rd_ram(base + 2, d); chk("R4 mark", d, VECS[v].mark);
            rd_ram(base + VECS[v].mark, d); chk("R6 first", d, pat(v + 1, 0));
            rd_ram(base + 255, d); chk("R6 last", d, pat(v + 1, 255 - VECS[v].mark));
        end

        // R9 stream while flag set
        send(8'hEE, 8'hEE, 8'd250, 8'h0, 1'b0, 6, 40, 1'b0, 8'h0);
        rd(12'h000, d); chk("R9 flag", d, 1);
        rd_ram(5 * 256, d); chk("R9 unwritten", d, 8'h14);

        // R3 mask
        wr_reg(2, 8'h01);
        chk("R3 irq on", irq, 1);
        wr_reg(1, 8'd2);
        chk("R3 irq off", irq, 0);
        rd(12'h001, d); chk("R2 page", d, 2);

        // R7 early end
        send(8'h31, 8'h32, 8'd250, 8'h0, 1'b0, 5, 50, 1'b0, 8'h0);
        rd(12'h000, d); chk("R7 flag", d, 0);
        // R8 long marker while disabled
        send(8'h33, 8'h34, 8'd0, 8'd200, 1'b1, 56, 51, 1'b0, 8'h0);
        rd(12'h000, d); chk("R8 flag", d, 0);
        // R12 marker too small
        send(8'h35, 8'h36, 8'd2, 8'h0, 1'b0, 254, 52, 1'b0, 8'h0);
        rd(12'h000, d); chk("R12 flag", d, 0);
        // R11 overlong
        send(8'h37, 8'h38, 8'd250, 8'h0, 1'b0, 7, 53, 1'b0, 8'h0);
        rd(12'h000, d); chk("R11 flag", d, 0);
        // R7 still armed: good packet on page 2
        send(8'h55, 8'h56, 8'd240, 8'h0, 1'b0, 16, 60, 1'b0, 8'h0);
        rd(12'h000, d); chk("R7 recovered", d, 1);
        chk("R3 irq done", irq, 1);
        rd_ram(512, d); chk("R7 sid", d, 8'h55);
        rd_ram(512 + 255, old255); chk("R7 last", old255, pat(60, 15));

        // R10 arm command coincides with final byte
        wr_reg(1, 8'd2);
        send(8'h57, 8'h58, 8'd240, 8'h0, 1'b0, 16, 61, 1'b1, 8'd6);
        rd(12'h000, d); chk("R10 flag", d, 0);
        rd(12'h001, d); chk("R10 page", d, 6);
        rd_ram(512 + 255, d); chk("R10 last kept", d, old255);
        send(8'h66, 8'h67, 8'd200, 8'h0, 1'b0, 56, 62, 1'b0, 8'h0);
        rd(12'h000, d); chk("R10 new page done", d, 1);
        rd_ram(6 * 256, d); chk("R10 new page sid", d, 8'h66);

        // R5 long packet, 512-byte pages
        long_en = 1'b1;
        wr_reg(1, 8'd3);
        send(8'h77, 8'h78, 8'd0, 8'd200, 1'b1, 56, 70, 1'b0, 8'h0);
        rd(12'h000, d); chk("R5 flag", d, 1);
        base = 3 * 512;
        rd_ram(base, d);       chk("R5 sid", d, 8'h77);
        rd_ram(base + 2, d);   chk("R5 zero", d, 0);
        rd_ram(base + 3, d);   chk("R5 loff", d, 200);
        rd_ram(base + 456, d); chk("R5 first", d, pat(70, 0));
        rd_ram(base + 511, d); chk("R5 last", d, pat(70, 55));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule